// File: doc/BRIEF.md
# Constant Reciprocal Fixed-Point Divider

This block divides an unsigned 24-bit integer sample by a fixed real constant greater than one. It does not use a divider. It multiplies the sample by a pre-scaled reciprocal held as an unsigned pure fraction (the real reciprocal times 2^24), which gives a 48-bit product. The upper half of that product is the integer quotient. The lower half is the fractional remainder, which the block drops from the quotient by truncation but still presents on its own output, so that a later stage (a noise-shaping loop, for instance) can use it.

The reciprocal is an elaboration-time parameter. Its default, 12336188, stands for division by 1.36. A second build option replaces the reciprocal with a coarse 13-bit factor: the sample is multiplied by 7301 and the result keeps its bits from bit 13 upward, which approximates division by 1.122. The pipeline depth is a parameter from one to three register stages, and the output valid strobe follows the input strobe with exactly that latency. The block accepts a new sample on every clock cycle.

Top module: `const_recip_div`

## Requirements
- R1: With the default reciprocal K = 12336188, each accepted sample D produces out_q = floor(D * K / 2^24).
- R2: out_frac equals bits 23..0 of the 48-bit product D * K, which are the bits dropped from the quotient.
- R3: out_valid is high in exactly the cycle that comes PIPE_DEPTH rising edges after the edge that sampled in_valid high, and it is low in every other cycle. The default PIPE_DEPTH is 2, and the allowed values are 1, 2 and 3.
- R4: While out_valid is low, out_q and out_frac keep the last result, whatever in_d holds.
- R5: An active-high rst clears out_q, out_frac, out_valid and every pipeline stage at once, with no clock edge needed. The outputs stay cleared until rst goes low.
- R6: D = 0 gives out_q = 0 and out_frac = 0. D = 16777215 gives out_q = 12336187 and out_frac = 4441028.
- R7: With USE_COARSE set, out_q = floor(D * 7301 / 8192), and out_frac holds the 13 dropped bits, shifted left by 11 places.
- R8: Samples presented on consecutive cycles each produce their own result on consecutive cycles, in order, with none lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset |
| in_valid | input | 1 | Marks in_d as a sample to divide |
| in_d | input | 24 | Unsigned integer dividend |
| out_valid | output | 1 | Marks out_q and out_frac as a new result |
| out_q | output | 24 | Truncated integer quotient |
| out_frac | output | 24 | Fractional bits dropped from the product |

## Verification
A reciprocal constant held wrongly, or a wrong slice of the product, shows up at out_q or out_frac on the first valid result, which is PIPE_DEPTH cycles after the sample went in. Large operands such as 16777215 reveal faults in the upper product bits that small operands never reach. A pipeline stage that is missing, duplicated or not reset moves out_valid by one cycle, or makes it pulse after a reset. The directed latency checks on a depth-2 instance and a depth-3 instance catch this at the first sample.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    localparam int unsigned DW = 24;
    localparam int unsigned FW = 24;
    localparam int unsigned PW = DW + FW;

    localparam logic [FW-1:0] RECIP_DEFAULT = 24'd12336188;

    localparam int unsigned COARSE_MULT  = 7301;
    localparam int unsigned COARSE_SHIFT = 13;

    typedef logic [DW-1:0] sample_t;
    typedef logic [FW-1:0] frac_t;
    typedef logic [PW-1:0] prod_t;

    typedef struct packed {
        logic    vld;
        sample_t d;
    } opnd_s;

    typedef struct packed {
        logic  vld;
        prod_t p;
    } prod_s;

    // A coarse factor scaled by 2^-COARSE_SHIFT equals the same factor moved up
    // into the 2^-FW fraction field.
    function automatic frac_t eff_recip(input frac_t k, input bit coarse);
        frac_t r;
        if (coarse) r = frac_t'(COARSE_MULT) << (FW - COARSE_SHIFT);
        else        r = k;
        return r;
    endfunction

    function automatic prod_t widen_mul(input sample_t a, input frac_t b);
        prod_t pa;
        prod_t pb;
        pa = prod_t'(a);
        pb = prod_t'(b);
        return pa * pb;
    endfunction

endpackage

// File: rtl/cdiv_opnd_stage.sv
module cdiv_opnd_stage
    import cdiv_pkg::*;
#(
    parameter bit REG = 1'b0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  sample_t in_d,
    output opnd_s   opnd
);

    opnd_s nxt;

    always_comb begin
        nxt.vld = in_valid;
        nxt.d   = in_d;
    end

    generate
        if (REG) begin : g_reg
            always_ff @(posedge clk or posedge rst) begin
                if (rst) opnd <= '0;
                else     opnd <= nxt;
            end
        end else begin : g_pass
            assign opnd = nxt;
        end
    endgenerate

endmodule

// File: rtl/cdiv_mult.sv
module cdiv_mult
    import cdiv_pkg::*;
#(
    parameter frac_t RECIP = RECIP_DEFAULT,
    parameter bit    REG   = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  opnd_s opnd,
    output prod_s prod
);

    prod_s nxt;

    always_comb begin
        nxt.vld = opnd.vld;
        nxt.p   = widen_mul(opnd.d, RECIP);
    end

    generate
        if (REG) begin : g_reg
            always_ff @(posedge clk or posedge rst) begin
                if (rst) prod <= '0;
                else     prod <= nxt;
            end
        end else begin : g_pass
            assign prod = nxt;
        end
    endgenerate

endmodule

// File: rtl/cdiv_out_reg.sv
module cdiv_out_reg
    import cdiv_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  prod_s   prod,
    output logic    out_valid,
    output sample_t out_q,
    output frac_t   out_frac
);

    sample_t q_nxt;
    frac_t   f_nxt;

    always_comb begin
        q_nxt = prod.p[PW-1:FW];
        f_nxt = prod.p[FW-1:0];
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_q     <= '0;
            out_frac  <= '0;
        end else begin
            out_valid <= prod.vld;
            if (prod.vld) begin
                out_q    <= q_nxt;
                out_frac <= f_nxt;
            end
        end
    end

endmodule

// File: rtl/const_recip_div.sv
module const_recip_div
    import cdiv_pkg::*;
#(
    parameter logic [23:0] RECIP      = RECIP_DEFAULT,
    parameter bit          USE_COARSE = 1'b0,
    parameter int unsigned PIPE_DEPTH = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [23:0] in_d,
    output logic        out_valid,
    output logic [23:0] out_q,
    output logic [23:0] out_frac
);

    localparam frac_t K_EFF    = eff_recip(RECIP, USE_COARSE);
    localparam bit    OPND_REG = (PIPE_DEPTH >= 3);
    localparam bit    MULT_REG = (PIPE_DEPTH >= 2);

    opnd_s opnd;
    prod_s prod;

    cdiv_opnd_stage #(.REG(OPND_REG)) u_opnd (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_d     (in_d),
        .opnd     (opnd)
    );

    cdiv_mult #(.RECIP(K_EFF), .REG(MULT_REG)) u_mult (
        .clk  (clk),
        .rst  (rst),
        .opnd (opnd),
        .prod (prod)
    );

    cdiv_out_reg u_out (
        .clk       (clk),
        .rst       (rst),
        .prod      (prod),
        .out_valid (out_valid),
        .out_q     (out_q),
        .out_frac  (out_frac)
    );

endmodule

// File: rtl/cdiv_checker.sv
module cdiv_checker #(
    parameter int unsigned DEPTH = 2,
    parameter logic [23:0] RECIP = 24'd12336188
) (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [23:0] in_d,
    input logic        out_valid,
    input logic [23:0] out_q,
    input logic [23:0] out_frac
);

    AST_QUOT_MATCH: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((({24'd0, $past(in_d, DEPTH)} * {24'd0, RECIP}) >> 24) == {24'd0, out_q})); // R1

    AST_FRAC_MATCH: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((({24'd0, $past(in_d, DEPTH)} * {24'd0, RECIP}) & 48'hFFFFFF) == {24'd0, out_frac})); // R2

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid, DEPTH)); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_q) && $stable(out_frac))); // R4

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |-> (!out_valid && out_q == 24'd0 && out_frac == 24'd0)); // R5

endmodule

bind const_recip_div cdiv_checker #(.DEPTH(PIPE_DEPTH), .RECIP(K_EFF)) u_cdiv_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_d      (in_d),
    .out_valid (out_valid),
    .out_q     (out_q),
    .out_frac  (out_frac)
);

// File: tb/const_recip_div_bench.sv
`timescale 1ns/1ps
module const_recip_div_bench;

    localparam logic [47:0] K_DEF = 48'd12336188;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [23:0] in_d = '0;

    logic        a_valid, c_valid;
    logic [23:0] a_q, a_frac, c_q, c_frac;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    // depth 2, default reciprocal
    const_recip_div u_const_recip_div (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_d(in_d),
        .out_valid(a_valid), .out_q(a_q), .out_frac(a_frac)
    );

    // depth 3, coarse factor
    const_recip_div #(.USE_COARSE(1'b1), .PIPE_DEPTH(3)) u_const_recip_div_crs (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_d(in_d),
        .out_valid(c_valid), .out_q(c_q), .out_frac(c_frac)
    );

    function automatic logic [47:0] exp_q(input logic [23:0] d);
        logic [47:0] p;
        p = {24'd0, d} * K_DEF;
        return p >> 24;
    endfunction

    function automatic logic [47:0] exp_f(input logic [23:0] d);
        logic [47:0] p;
        p = {24'd0, d} * K_DEF;
        return {24'd0, p[23:0]};
    endfunction

    function automatic logic [47:0] exp_cq(input logic [23:0] d);
        logic [47:0] p;
        p = {24'd0, d} * 48'd7301;
        return p / 48'd8192;
    endfunction

    function automatic logic [47:0] exp_cf(input logic [23:0] d);
        logic [47:0] p;
        p = {24'd0, d} * 48'd7301;
        return (p % 48'd8192) * 48'd2048;
    endfunction

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic t_reset_state();
        check("R5 a_valid after reset", {47'd0, a_valid}, 48'd0);
        check("R5 a_q after reset", {24'd0, a_q}, 48'd0);
        check("R5 a_frac after reset", {24'd0, a_frac}, 48'd0);
        check("R5 c_valid after reset", {47'd0, c_valid}, 48'd0);
    endtask

    // one sample; depth-2 result due at 2nd negedge, depth-3 at 3rd
    task automatic t_single(input logic [23:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_d = d;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_d = 24'h5A5A5A ^ 24'(k);
            check("R3 depth2 valid timing", {47'd0, a_valid}, (k == 2) ? 48'd1 : 48'd0);
            check("R3 depth3 valid timing", {47'd0, c_valid}, (k == 3) ? 48'd1 : 48'd0);
            if (k == 2) begin
                check("R1 quotient", {24'd0, a_q}, exp_q(d));
                check("R2 fraction", {24'd0, a_frac}, exp_f(d));
            end
            if (k == 3) begin
                check("R7 coarse quotient", {24'd0, c_q}, exp_cq(d));
                check("R7 coarse fraction", {24'd0, c_frac}, exp_cf(d));
            end
        end
    endtask

    task automatic t_extremes();
        t_single(24'd0);
        check("R6 zero quotient", {24'd0, a_q}, 48'd0);
        check("R6 zero fraction", {24'd0, a_frac}, 48'd0);
        @(negedge clk);
        in_valid = 1'b1;
        in_d = 24'hFFFFFF;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R6 max quotient", {24'd0, a_q}, 48'd12336187);
        check("R6 max fraction", {24'd0, a_frac}, 48'd4441028);
        @(negedge clk);
        check("R6 max coarse quotient", {24'd0, c_q}, exp_cq(24'hFFFFFF));
    endtask

    task automatic t_hold();
        logic [23:0] q0, f0, cq0;
        t_single(24'd1360000);
        q0 = a_q;
        f0 = a_frac;
        cq0 = c_q;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            in_d = 24'(k * 3333331 + 7);
            check("R4 quotient held", {24'd0, a_q}, {24'd0, q0});
            check("R4 fraction held", {24'd0, a_frac}, {24'd0, f0});
            check("R4 coarse held", {24'd0, c_q}, {24'd0, cq0});
        end
    endtask

    function automatic logic [23:0] vec(input int i);
        return 24'(i * 1234567 + 89);
    endfunction

    task automatic t_stream();
        localparam int N = 10;
        for (int i = 0; i < N + 4; i++) begin
            @(negedge clk);
            if (i >= 2 && i - 2 < N) begin
                check("R8 stream valid", {47'd0, a_valid}, 48'd1);
                check("R8 stream quotient", {24'd0, a_q}, exp_q(vec(i - 2)));
                check("R8 stream fraction", {24'd0, a_frac}, exp_f(vec(i - 2)));
            end else begin
                check("R8 stream idle", {47'd0, a_valid}, 48'd0);
            end
            if (i >= 3 && i - 3 < N) begin
                check("R8 coarse stream", {24'd0, c_q}, exp_cq(vec(i - 3)));
            end
            in_valid = (i < N);
            in_d = vec(i);
        end
        in_valid = 1'b0;
    endtask

    task automatic t_async_reset();
        @(negedge clk);
        in_valid = 1'b1;
        in_d = 24'hABCDEF;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        #1;
        rst = 1'b1;
        #1;
        check("R5 async clear q", {24'd0, a_q}, 48'd0);
        check("R5 async clear frac", {24'd0, a_frac}, 48'd0);
        check("R5 async clear valid", {47'd0, c_valid}, 48'd0);
        repeat (4) @(negedge clk);
        check("R5 held in reset", {24'd0, c_q}, 48'd0);
        rst = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R5 flushed a_valid", {47'd0, a_valid}, 48'd0);
            check("R5 flushed c_valid", {47'd0, c_valid}, 48'd0);
        end
        t_single(24'd1234);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_single(24'd1);
        t_single(24'd136);
        t_single(24'd1234);
        t_single(24'hABCDEF);
        t_single(24'h800000);
        t_extremes();
        t_hold();
        t_stream();
        t_async_reset();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R3: actual timeout expected completion");
        finish_run();
    end

endmodule